// File: doc/BRIEF.md
# Countdown Timer with Shared Interrupt Status

The block holds a single 32-bit control word that carries a down-counter value, a run enable, an interrupt enable and an acknowledge action. While running, the counter drops by one on each tick-enable pulse. When it steps from one to zero with the interrupt enabled, a timer pending flag is set. On the next tick at zero the counter reloads the value last written and keeps counting, so the timer repeats until it is stopped.

The block also builds an 8-bit device interrupt status word. The low five bits follow the request lines of the other units. The timer pending flag occupies its own bit. The single interrupt output is the OR of the whole status word. Software acknowledges the timer by writing the acknowledge bit through the control byte lane. Such a write clears the flag and leaves the run and interrupt enables as they were.

Control word layout: bits 19:0 count value, bit 24 run enable, bit 25 interrupt enable, bit 26 acknowledge on write and pending flag on read. All other bits read as zero. Status layout: bit 0 playback, bit 1 record, bit 2 serial audio out, bit 3 game port, bit 4 MIDI, bit 5 timer, bits 7:6 reserved and zero.

Top module: `cdtimer_irq`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0 with all request lines low, and the interrupt output is low.
- R2: A write with any of byte lanes 0..2 enabled loads bits 19:0 into both the live count and the reload value. Disabled lanes keep the bits of the last written value. The count is visible on read one cycle later, and bits 23:20 read 0.
- R3: With bit 24 set, each cycle with tick high lowers a nonzero count by one. With bit 24 clear, or with tick low, the count holds.
- R4: A tick that takes the count from 1 to 0 while bit 25 is set sets the pending flag. The flag then reads as bit 26 of the control word and bit 5 of the status word.
- R5: A running count that is already 0 never sets the flag. A 1-to-0 step while bit 25 is clear also never sets it.
- R6: A tick that finds the count at 0 while running loads the last written value and counting continues.
- R7: A lane-3 write with bit 26 set clears the pending flag and leaves bits 24 and 25 unchanged. A lane-3 write with bit 26 clear loads bits 24 and 25. If an expiry and an acknowledge fall in the same cycle, the flag stays set.
- R8: Status bits 4:0 follow the five request inputs in the same cycle, and bits 7:6 read 0. The interrupt output is high exactly when any status bit is high.
- R9: A count write and a tick in the same cycle leave the written value, and that tick neither decrements nor expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_be | input | 4 | Byte-lane enables of the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control word |
| tick | input | 1 | Count-enable pulse |
| src_req | input | 5 | Request lines of the other units |
| irq_status | output | 8 | Device interrupt status word |
| irq | output | 1 | Combined interrupt |

## Verification
The bench goes after the zero boundary. A design that fires on a count that is already zero would give a pending flag forever after a zero write. A design that forgets to reload would stall at zero after the first expiry. It also aims acknowledge writes at a running timer. A design that treats the acknowledge as a plain control write would stop the timer or mask its interrupt. Same-cycle collisions of a write with a tick, and of an expiry with an acknowledge, are forced on purpose. A wrong priority there shows up as a skipped count or a lost interrupt.

// File: rtl/cdtimer_irq.sv
module cdtimer_irq #(
  parameter int VAL_W = 20,
  parameter int N_SRC = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_be,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        tick,
  input  logic [N_SRC-1:0] src_req,
  output logic [7:0]  irq_status,
  output logic        irq
);
  localparam int B_RUN = 24;
  localparam int B_IEN = 25;
  localparam int B_ACK = 26;
  localparam int TMR_BIT = N_SRC;

  logic [VAL_W-1:0] count, reload;
  logic run, ien, pend;

  logic [31:0] lane_mask;
  assign lane_mask = {{8{reg_be[3]}}, {8{reg_be[2]}}, {8{reg_be[1]}}, {8{reg_be[0]}}};

  wire val_wr = reg_wr && (|reg_be[2:0]);
  wire ctl_wr = reg_wr && reg_be[3] && !reg_wdata[B_ACK];
  wire ack_wr = reg_wr && reg_be[3] && reg_wdata[B_ACK];
  wire step   = tick && run;
  wire expire = step && (count == VAL_W'(1)) && !val_wr;

  logic [VAL_W-1:0] val_next;
  assign val_next = (reload & ~lane_mask[VAL_W-1:0]) | (reg_wdata[VAL_W-1:0] & lane_mask[VAL_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      reload <= '0;
      run    <= 1'b0;
      ien    <= 1'b0;
      pend   <= 1'b0;
    end else begin
      if (val_wr) begin
        count  <= val_next;
        reload <= val_next;
      end else if (step) begin
        count <= (count == '0) ? reload : count - VAL_W'(1);
      end
      if (ctl_wr) begin
        run <= reg_wdata[B_RUN];
        ien <= reg_wdata[B_IEN];
      end
      if (expire && ien) pend <= 1'b1;
      else if (ack_wr)   pend <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    reg_rdata[VAL_W-1:0] = count;
    reg_rdata[B_RUN] = run;
    reg_rdata[B_IEN] = ien;
    reg_rdata[B_ACK] = pend;
  end

  always_comb begin
    irq_status = '0;
    irq_status[N_SRC-1:0] = src_req;
    irq_status[TMR_BIT] = pend;
  end

  assign irq = |irq_status;

  a_r4_expiry_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reg_rdata[B_RUN] && reg_rdata[B_IEN] && reg_rdata[VAL_W-1:0] == VAL_W'(1) && !val_wr)
      |=> irq_status[TMR_BIT]);

  a_r5_no_spurious_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[B_ACK] && !(tick && reg_rdata[B_RUN] && reg_rdata[VAL_W-1:0] == VAL_W'(1)))
      |=> !reg_rdata[B_ACK]);

  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reg_rdata[B_RUN] && reg_rdata[VAL_W-1:0] > VAL_W'(1) && !val_wr)
      |=> reg_rdata[VAL_W-1:0] == $past(reg_rdata[VAL_W-1:0]) - VAL_W'(1));

  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reg_rdata[B_RUN] && reg_rdata[VAL_W-1:0] == '0 && !val_wr)
      |=> reg_rdata[VAL_W-1:0] == $past(reload));

  a_r7_ack_keeps_enables: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> $stable(reg_rdata[B_IEN:B_RUN]));
endmodule

// File: tb/cdtimer_irq_bench.sv
module cdtimer_irq_bench;
  logic clk = 0, rst_n = 0, reg_wr = 0, tick = 0, irq;
  logic [3:0] reg_be = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [4:0] src_req = 0;
  logic [7:0] irq_status;
  int nvec = 0, nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cdtimer_irq u_cdtimer_irq (.clk, .rst_n, .reg_wr, .reg_be, .reg_wdata, .reg_rdata,
    .tick, .src_req, .irq_status, .irq);

  logic [19:0] m_cnt, m_rel;
  logic m_run, m_ien, m_pend;

  function automatic logic [31:0] exp_rd();
    return {5'b0, m_pend, m_ien, m_run, 4'b0, m_cnt};
  endfunction
  function automatic logic [7:0] exp_st();
    return {2'b0, m_pend, src_req};
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_rel = 0; m_run = 0; m_ien = 0; m_pend = 0;
  endtask

  task automatic model_step(logic we, logic [3:0] be, logic [31:0] wd, logic tk);
    logic [31:0] msk;
    logic [19:0] nv;
    logic valwr, ctl, ack, expire;
    msk = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    nv = (m_rel & ~msk[19:0]) | (wd[19:0] & msk[19:0]);
    valwr = we && (|be[2:0]);
    ctl = we && be[3] && !wd[26];
    ack = we && be[3] && wd[26];
    expire = tk && m_run && m_cnt == 20'd1 && !valwr;
    if (expire && m_ien) m_pend = 1;
    else if (ack) m_pend = 0;
    if (valwr) begin m_cnt = nv; m_rel = nv; end
    else if (tk && m_run) m_cnt = (m_cnt == 0) ? m_rel : m_cnt - 20'd1;
    if (ctl) begin m_run = wd[24]; m_ien = wd[25]; end
  endtask

  task automatic check(string tag);
    nvec++;
    if (reg_rdata !== exp_rd() || irq_status !== exp_st() || irq !== (|exp_st())) begin
      nerr++;
      $display("FAIL %s: rd=%h st=%h irq=%b expected rd=%h st=%h irq=%b",
               tag, reg_rdata, irq_status, irq, exp_rd(), exp_st(), |exp_st());
    end
  endtask

  task automatic cyc(logic we, logic [3:0] be, logic [31:0] wd, logic tk, logic [4:0] src, string tag);
    @(negedge clk);
    reg_wr = we; reg_be = be; reg_wdata = wd; tick = tk; src_req = src;
    @(posedge clk);
    model_step(we, be, wd, tk);
    #2;
    reg_wr = 0; tick = 0;
    check(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1 check("R1 reset state");

    cyc(1, 4'b0111, 32'h0000_0003, 0, 0, "R2 count write");
    cyc(0, 0, 0, 1, 0, "R3 tick while stopped holds");
    cyc(1, 4'b1000, 32'h0300_0000, 0, 0, "R7 control write enables");
    cyc(0, 0, 0, 0, 0, "R3 no tick holds");
    cyc(0, 0, 0, 1, 0, "R3 decrement 3->2");
    cyc(0, 0, 0, 1, 0, "R3 decrement 2->1");
    cyc(0, 0, 0, 1, 0, "R4 expiry sets flag");
    cyc(0, 0, 0, 1, 0, "R6 reload at zero");
    cyc(1, 4'b1000, 32'h0400_0000, 0, 0, "R7 ack clears flag keeps enables");
    cyc(1, 4'b0010, 32'h0000_0100, 0, 0, "R2 lane merge with last value");
    cyc(1, 4'b1111, 32'h04F0_0001, 0, 0, "R2 upper bits read zero, R7 ack keeps enables");
    cyc(1, 4'b1000, 32'h0400_0000, 1, 0, "R7 expiry wins over ack");
    cyc(1, 4'b0111, 32'h0000_0000, 0, 0, "R5 zero write");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, 0, "R5 zero count no trigger");
    cyc(1, 4'b1000, 32'h0400_0000, 0, 0, "R7 ack");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, 0, "R5 flag stays clear at zero");
    cyc(1, 4'b0111, 32'h0000_0005, 0, 0, "R2 write 5");
    cyc(1, 4'b0111, 32'h0000_0009, 1, 0, "R9 write beats tick");
    cyc(1, 4'b0111, 32'h0000_0001, 0, 0, "R2 write 1");
    cyc(1, 4'b0111, 32'h0000_0007, 1, 0, "R9 write suppresses expiry");
    cyc(1, 4'b1000, 32'h0100_0000, 0, 0, "R7 interrupt disable");
    cyc(1, 4'b0111, 32'h0000_0001, 0, 0, "R2 write 1");
    cyc(0, 0, 0, 1, 0, "R5 expiry with interrupt disabled");
    for (int i = 0; i < 5; i++) cyc(0, 0, 5'(1 << i), 0, 5'(1 << i), "R8 single source");
    cyc(0, 0, 0, 0, 5'h1F, "R8 all sources");
    cyc(0, 0, 0, 0, 5'h00, "R8 no source");

    for (int i = 0; i < 4000; i++) begin
      logic we, tk;
      logic [3:0] be;
      logic [31:0] wd;
      we = ($urandom_range(0, 9) == 0);
      be = 4'($urandom);
      wd = $urandom & 32'h07FF_FFFF;
      if ($urandom_range(0, 1) == 1) wd[19:0] = 20'($urandom_range(0, 4));
      tk = ($urandom_range(0, 2) != 0);
      cyc(we, be, wd, tk, 5'($urandom), "R3 R4 R6 R7 R8 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial void'($urandom(32'd7));
endmodule